// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects interrupt requests from sixteen sources and hands the CPU one request at a time, together with the handler address to jump to. Every source owns a writable handler-address register, so there is no fixed vector table: software stores the address of each service routine in the controller. The CPU then receives that address directly with the request.

Requests reach a per-source pending flag in two ways. One is a hardware input, which is edge-sensitive or level-sensitive per source, chosen by a parameter mask. The other is a software write to a raise register, which sets pending flags exactly as hardware does. An enable mask decides which pending flags may be forwarded. Among the forwardable ones, the lowest-numbered source wins.

The winning source's handler address is latched and presented with the request line. Both stay frozen until the CPU acknowledges. The acknowledge clears that source's pending flag and frees the controller to pick the next winner.

Top module: `vic_top`

## Requirements
- R1: After reset, `cpu_irq` is 0, `cpu_vector` is 0, and every handler-address register, the enable mask and all pending flags read 0.
- R2: Bus address i (0 to 15) holds the handler address of source i in read data bits [23:0]. A write stores `bus_wdata[23:0]`, and bits [31:24] always read 0.
- R3: For an edge-type source, a rising level on `src_in[i]` sets pending bit i at the next clock edge. A source that stays high after acknowledge is not pending again.
- R4: For a level-type source (bit i of `LEVEL_MASK` set; by default sources 12 to 15), pending bit i is set on every clock edge at which `src_in[i]` is high. Such a source is therefore requested again after acknowledge while its input stays high.
- R5: A write to address 17 sets pending bit i for each data bit i that is 1 and leaves the other pending bits unchanged. A read of address 17 returns the pending flags in bits [15:0].
- R6: Address 16 is the enable mask (bit i enables source i). A pending source whose enable bit is 0 stays pending but never raises `cpu_irq`. Once it is enabled, it is forwarded.
- R7: When several pending sources are enabled, the one with the lowest index is served first.
- R8: When `cpu_irq` is low and some source is pending and enabled, `cpu_irq` rises one clock later. `cpu_vector` then equals the handler address of the served source.
- R9: While `cpu_irq` is high and `cpu_ack` is low, `cpu_irq` and `cpu_vector` hold their values. This holds even if a higher-priority request arrives or the served source's handler register is rewritten.
- R10: `cpu_ack` sampled high while `cpu_irq` is high clears the served source's pending bit and drops `cpu_irq` on the next clock. `cpu_ack` while `cpu_irq` is low has no effect.
- R11: If a new request for the served source (hardware or software) arrives on the same clock as its acknowledge, the request wins. The source stays pending and is served again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | 16 | Hardware request inputs, one per source |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` (combinational) |
| cpu_irq | output | 1 | Interrupt request to the CPU |
| cpu_vector | output | 24 | Handler word address of the served source |
| cpu_ack | input | 1 | CPU acknowledge of the current request |

## Verification
The hardest situation to reach from the ports is a new request for the source being served landing on the very clock of its acknowledge. The bench drives the raise-register write and `cpu_ack` from the same falling edge, so both are sampled at one rising edge. It then expects an immediate second request with the same handler address. Priority against a frozen request is also hard to reach. The bench raises a higher-priority source and rewrites the served handler register while the CPU has not yet acknowledged, and checks that nothing at the CPU side moves until the acknowledge.

// File: rtl/vic_pkg.sv
package vic_pkg;

   typedef enum logic [1:0] {
      RK_VECTOR = 2'd0,
      RK_ENABLE = 2'd1,
      RK_RAISE  = 2'd2,
      RK_NONE   = 2'd3
   } reg_kind_e;

   // Handler registers occupy 0..n_src-1, then enable mask, then raise/pending.
   function automatic reg_kind_e decode_reg(input int unsigned addr,
                                            input int unsigned n_src);
      if (addr < n_src)          return RK_VECTOR;
      else if (addr == n_src)    return RK_ENABLE;
      else if (addr == n_src + 1) return RK_RAISE;
      else                       return RK_NONE;
   endfunction

endpackage

// File: rtl/vic_capture.sv
module vic_capture #(
   parameter int              N_SRC      = 16,
   parameter logic [N_SRC-1:0] LEVEL_MASK = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src_in,
   output logic [N_SRC-1:0] set_o
);

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      if (LEVEL_MASK[i]) begin : g_level
         assign set_o[i] = src_in[i];
      end else begin : g_edge
         logic prev_q;
         always_ff @(posedge clk) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= src_in[i];
         end
         assign set_o[i] = src_in[i] & ~prev_q;
      end
   end

endmodule

// File: rtl/vic_pending.sv
module vic_pending #(
   parameter int N_SRC = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] set_hw,
   input  logic [N_SRC-1:0] set_sw,
   input  logic [N_SRC-1:0] clr,
   output logic [N_SRC-1:0] pend_o
);

   logic [N_SRC-1:0] pend_q;

   // A set arriving with a clear wins, so no request is lost.
   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~clr) | set_hw | set_sw;
   end

   assign pend_o = pend_q;

endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
   parameter int N_SRC = 16,
   parameter int IDX_W = $clog2(N_SRC)
) (
   input  logic [N_SRC-1:0] req,
   output logic             valid,
   output logic [IDX_W-1:0] idx
);

   always_comb begin
      valid = 1'b0;
      idx   = '0;
      for (int i = N_SRC - 1; i >= 0; i--) begin
         if (req[i]) begin
            valid = 1'b1;
            idx   = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/vic_vecbank.sv
module vic_vecbank #(
   parameter int N_SRC = 16,
   parameter int VEC_W = 24,
   parameter int IDX_W = $clog2(N_SRC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [VEC_W-1:0] wr_data,
   input  logic [IDX_W-1:0] rda_idx,
   output logic [VEC_W-1:0] rda_data,
   input  logic [IDX_W-1:0] rdb_idx,
   output logic [VEC_W-1:0] rdb_data
);

   logic [N_SRC-1:0][VEC_W-1:0] vec_q;

   for (genvar i = 0; i < N_SRC; i++) begin : g_vec
      always_ff @(posedge clk) begin
         if (!rst_n)
            vec_q[i] <= '0;
         else if (wr_en && (wr_idx == IDX_W'(i)))
            vec_q[i] <= wr_data;
      end
   end

   assign rda_data = vec_q[rda_idx];
   assign rdb_data = vec_q[rdb_idx];

endmodule

// File: rtl/vic_top.sv
module vic_top
   import vic_pkg::*;
#(
   parameter int               N_SRC      = 16,
   parameter int               VEC_W      = 24,
   parameter int               DATA_W     = 32,
   parameter int               ADDR_W     = 5,
   parameter logic [N_SRC-1:0] LEVEL_MASK = 16'hF000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  src_in,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              cpu_irq,
   output logic [VEC_W-1:0]  cpu_vector,
   input  logic              cpu_ack
);

   localparam int IDX_W = $clog2(N_SRC);

   if (N_SRC < 2 || N_SRC > DATA_W) begin : g_bad_nsrc
      $error("vic_top: N_SRC must lie in 2..DATA_W");
   end
   if (VEC_W > DATA_W) begin : g_bad_vecw
      $error("vic_top: VEC_W must not exceed DATA_W");
   end
   if (N_SRC + 2 > (1 << ADDR_W)) begin : g_bad_addrw
      $error("vic_top: ADDR_W too narrow for the register set");
   end

   reg_kind_e        kind;
   logic [N_SRC-1:0] hw_set, sw_set, clr, pend_q, en_q, eligible;
   logic             win_valid;
   logic [IDX_W-1:0] win_idx, cur_idx_q;
   logic [VEC_W-1:0] win_vec, rd_vec, cur_vec_q;
   logic             busy_q, take;
   logic             unused_wdata;

   assign kind         = decode_reg(32'(bus_addr), N_SRC);
   assign unused_wdata = ^bus_wdata;

   vic_capture #(.N_SRC(N_SRC), .LEVEL_MASK(LEVEL_MASK)) u_capture (
      .clk    (clk),
      .rst_n  (rst_n),
      .src_in (src_in),
      .set_o  (hw_set)
   );

   assign sw_set = (bus_we && kind == RK_RAISE) ? bus_wdata[N_SRC-1:0] : '0;
   assign clr    = (busy_q && cpu_ack) ? (N_SRC'(1) << cur_idx_q) : '0;

   vic_pending #(.N_SRC(N_SRC)) u_pending (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_hw (hw_set),
      .set_sw (sw_set),
      .clr    (clr),
      .pend_o (pend_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         en_q <= '0;
      else if (bus_we && kind == RK_ENABLE)
         en_q <= bus_wdata[N_SRC-1:0];
   end

   assign eligible = pend_q & en_q;

   vic_arbiter #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_arbiter (
      .req   (eligible),
      .valid (win_valid),
      .idx   (win_idx)
   );

   vic_vecbank #(.N_SRC(N_SRC), .VEC_W(VEC_W), .IDX_W(IDX_W)) u_vecbank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bus_we && kind == RK_VECTOR),
      .wr_idx   (bus_addr[IDX_W-1:0]),
      .wr_data  (bus_wdata[VEC_W-1:0]),
      .rda_idx  (win_idx),
      .rda_data (win_vec),
      .rdb_idx  (bus_addr[IDX_W-1:0]),
      .rdb_data (rd_vec)
   );

   // A new grant only from idle; the latched source and address are frozen until ack.
   assign take = !busy_q && win_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         cur_idx_q <= '0;
         cur_vec_q <= '0;
      end else if (take) begin
         busy_q    <= 1'b1;
         cur_idx_q <= win_idx;
         cur_vec_q <= win_vec;
      end else if (busy_q && cpu_ack) begin
         busy_q    <= 1'b0;
      end
   end

   assign cpu_irq    = busy_q;
   assign cpu_vector = cur_vec_q;

   always_comb begin
      unique case (kind)
         RK_VECTOR: bus_rdata = DATA_W'(rd_vec);
         RK_ENABLE: bus_rdata = DATA_W'(en_q);
         RK_RAISE:  bus_rdata = DATA_W'(pend_q);
         default:   bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/vic_top_chk.sv
module vic_top_chk #(
   parameter int N_SRC = 16,
   parameter int VEC_W = 24,
   parameter int IDX_W = $clog2(N_SRC)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cpu_irq,
   input logic             cpu_ack,
   input logic [VEC_W-1:0] cpu_vector,
   input logic [N_SRC-1:0] pend,
   input logic [N_SRC-1:0] enable,
   input logic [IDX_W-1:0] cur_idx
);

   AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq && !cpu_ack |=> cpu_irq); // R9

   AST_VECTOR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq && !cpu_ack |=> $stable(cpu_vector)); // R9

   AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq && cpu_ack |=> !cpu_irq); // R10

   AST_SERVED_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq |-> pend[cur_idx]); // R10

   AST_RAISE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_irq && ((pend & enable) != '0) |=> cpu_irq); // R8

   AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_irq && ((pend & enable) == '0) |=> !cpu_irq); // R6

endmodule

bind vic_top vic_top_chk #(.N_SRC(N_SRC), .VEC_W(VEC_W), .IDX_W(IDX_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cpu_irq    (cpu_irq),
   .cpu_ack    (cpu_ack),
   .cpu_vector (cpu_vector),
   .pend       (pend_q),
   .enable     (en_q),
   .cur_idx    (cur_idx_q)
);

// File: tb/vic_top_test.sv
module vic_top_test;

   localparam int ADDR_EN    = 16;
   localparam int ADDR_RAISE = 17;
   localparam logic [1:0] OP_WR = 2'd1;
   localparam logic [1:0] OP_RD = 2'd2;
   localparam int NV = 14;

   // {op, addr, data, expected read}
   localparam logic [70:0] TBL [NV] = '{
      {OP_RD, 5'd16, 32'h0,         32'h0},        // R1
      {OP_RD, 5'd17, 32'h0,         32'h0},        // R1
      {OP_RD, 5'd3,  32'h0,         32'h0},        // R1
      {OP_WR, 5'd0,  32'hFFFF_FFFF, 32'h0},
      {OP_RD, 5'd0,  32'h0,         32'h00FF_FFFF},// R2
      {OP_WR, 5'd5,  32'h0012_3456, 32'h0},
      {OP_RD, 5'd5,  32'h0,         32'h0012_3456},// R2
      {OP_RD, 5'd4,  32'h0,         32'h0},        // R2
      {OP_WR, 5'd16, 32'h0000_00F0, 32'h0},
      {OP_RD, 5'd16, 32'h0,         32'h0000_00F0},// R6
      {OP_WR, 5'd17, 32'h0000_0100, 32'h0},
      {OP_RD, 5'd17, 32'h0,         32'h0000_0100},// R5
      {OP_WR, 5'd17, 32'h0000_0001, 32'h0},
      {OP_RD, 5'd17, 32'h0,         32'h0000_0101} // R5
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] src_in = '0;
   logic        bus_we = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        cpu_irq;
   logic [23:0] cpu_vector;
   logic        cpu_ack = 1'b0;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   vic_top uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_in     (src_in),
      .bus_we     (bus_we),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .cpu_irq    (cpu_irq),
      .cpu_vector (cpu_vector),
      .cpu_ack    (cpu_ack)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic bus_write(input int a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = 5'(a); bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   // Caller is at a falling edge; combinational read, no clock consumed.
   task automatic bus_read(input int a, output logic [31:0] d);
      bus_addr = 5'(a);
      #1 d = bus_rdata;
   endtask

   task automatic ack_pulse();
      @(negedge clk);
      cpu_ack = 1'b1;
      @(negedge clk);
      cpu_ack = 1'b0;
   endtask

   task automatic expect_cpu(input string req, input logic irq, input logic [23:0] vec);
      chk(req, 32'(cpu_irq), 32'(irq));
      if (irq) chk(req, 32'(cpu_vector), 32'(vec));
   endtask

   initial begin
      #(20 * 20000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      do_reset();
      @(negedge clk);
      chk("R1 irq", 32'(cpu_irq), 32'h0);
      chk("R1 vector", 32'(cpu_vector), 32'h0);

      for (int k = 0; k < NV; k++) begin
         if (TBL[k][70:69] == OP_WR) begin
            bus_write(int'(TBL[k][68:64]), TBL[k][63:32]);
         end else begin
            @(negedge clk);
            bus_read(int'(TBL[k][68:64]), rd);
            chk($sformatf("R1/R2/R5/R6 table row %0d", k), rd, TBL[k][31:0]);
         end
      end
      @(negedge clk);
      chk("R6 masked pending no irq", 32'(cpu_irq), 32'h0);

      // Fresh start for the CPU-side tests.
      do_reset();
      bus_write(4, 32'h444);
      bus_write(2, 32'h222);
      bus_write(9, 32'h999);
      bus_write(8, 32'h888);
      bus_write(13, 32'hD0D);
      bus_write(ADDR_EN, 32'h0214);

      // R3 / R8: edge source 4
      @(negedge clk);
      src_in[4] = 1'b1;
      @(negedge clk);
      chk("R8 irq not yet", 32'(cpu_irq), 32'h0);
      bus_read(ADDR_RAISE, rd);
      chk("R3 edge sets pending", rd, 32'h0010);
      @(negedge clk);
      expect_cpu("R8 request with vector", 1'b1, 24'h444);

      // R9: higher priority arrives and vector rewritten while unacked
      bus_write(ADDR_RAISE, 32'h0004);
      bus_write(4, 32'hAAA);
      expect_cpu("R9 held through new request", 1'b1, 24'h444);

      // R10: ack clears served bit
      ack_pulse();
      chk("R10 irq drops after ack", 32'(cpu_irq), 32'h0);
      bus_read(ADDR_RAISE, rd);
      chk("R10/R3 pending after ack", rd, 32'h0004);
      @(negedge clk);
      expect_cpu("R7 next source 2", 1'b1, 24'h222);
      ack_pulse();
      @(negedge clk);
      chk("R3 steady high no re-pend", 32'(cpu_irq), 32'h0);
      bus_read(ADDR_RAISE, rd);
      chk("R3 pending empty", rd, 32'h0);
      src_in[4] = 1'b0;

      // R7: three simultaneous software requests
      bus_write(ADDR_RAISE, 32'h0214);
      @(negedge clk);
      expect_cpu("R7 lowest first", 1'b1, 24'h222);
      ack_pulse();
      @(negedge clk);
      expect_cpu("R7 second", 1'b1, 24'hAAA);
      ack_pulse();
      @(negedge clk);
      expect_cpu("R7 third", 1'b1, 24'h999);
      ack_pulse();
      @(negedge clk);
      chk("R7 all served", 32'(cpu_irq), 32'h0);

      // R6: masked source stays pending, forwarded after enable
      bus_write(ADDR_RAISE, 32'h0100);
      @(negedge clk);
      @(negedge clk);
      chk("R6 masked no irq", 32'(cpu_irq), 32'h0);
      bus_read(ADDR_RAISE, rd);
      chk("R6 masked still pending", rd, 32'h0100);
      bus_write(ADDR_EN, 32'h2314);
      @(negedge clk);
      expect_cpu("R6 enabled forwards", 1'b1, 24'h888);
      ack_pulse();

      // R4: level source 13 re-requests while high
      @(negedge clk);
      src_in[13] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      expect_cpu("R4 level request", 1'b1, 24'hD0D);
      ack_pulse();
      chk("R4 drop after ack", 32'(cpu_irq), 32'h0);
      @(negedge clk);
      expect_cpu("R4 re-request while high", 1'b1, 24'hD0D);
      src_in[13] = 1'b0;
      ack_pulse();
      @(negedge clk);
      chk("R4 quiet after release", 32'(cpu_irq), 32'h0);

      // R10: ack while idle is ignored
      bus_write(ADDR_RAISE, 32'h0002);
      ack_pulse();
      @(negedge clk);
      bus_read(ADDR_RAISE, rd);
      chk("R10 idle ack ignored", rd, 32'h0002);
      chk("R10 idle ack no irq", 32'(cpu_irq), 32'h0);

      // R11: re-raise on the same clock as ack
      bus_write(ADDR_RAISE, 32'h0200);
      @(negedge clk);
      expect_cpu("R11 setup", 1'b1, 24'h999);
      @(negedge clk);
      cpu_ack = 1'b1;
      bus_we = 1'b1; bus_addr = 5'(ADDR_RAISE); bus_wdata = 32'h0200;
      @(negedge clk);
      cpu_ack = 1'b0; bus_we = 1'b0;
      chk("R11 irq drops", 32'(cpu_irq), 32'h0);
      @(negedge clk);
      expect_cpu("R11 served again", 1'b1, 24'h999);
      ack_pulse();
      @(negedge clk);
      bus_read(ADDR_RAISE, rd);
      chk("R11 cleared after second ack", rd, 32'h0002);

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule